// File: doc/BRIEF.md
# Memory Bandwidth Traffic Generator

This block exercises one memory channel by generating a configurable stream of read, write or read-then-write-back (copy) traffic over `n` elements. It talks to the channel through five independent valid/ready queues: read address out, read data in, write address out, write data out and write acknowledge in. Addresses are either sequential (the element index of that direction) or pseudo-random, taken from a 16-bit shift-register generator and confined to a power-of-two window derived from `n`.

Software-visible configuration is a plain length and three mode pins, sampled on a start pulse while the block is idle. The block caps the number of reads in flight, couples each returning read beat to a write-back in copy mode, credits write acknowledges that may cover several writes at once, and raises `done` when the last expected response has arrived.

Back-pressure rules: a beat moves on a queue in every cycle where its valid and ready are both high. The address outputs never depend on the matching ready. The write address and write data queues form a pair: both valids are raised together, only in a cycle where both readies are high, and the pair moves in that cycle. `rd_ready` in copy mode depends on both write readies, so a read beat is consumed exactly when its write-back pair moves.

Top module: `bw_traffic_gen`

## Requirements
- R1: A `start` pulse while idle latches `cfg_len`, `cfg_read`, `cfg_write` and `cfg_random`; a `start` while a run is in progress is ignored and does not change the run.
- R2: If at start neither `cfg_read` nor `cfg_write` is set, or `cfg_len` is 0, `done` is high from the next cycle and no request or ready is ever raised.
- R3: With `cfg_random` low, each request address equals the count of requests already accepted in that direction since start (0, 1, 2, ...).
- R4: With `cfg_random` high, each direction has its own 16-bit generator reset to 0xBEEF at start and stepped once per accepted request, next state `{s[14:0], s[15]^s[13]^s[12]^s[10]}`; the address is the state ANDed with a mask that is 0xFFFF for n >= 65536 and otherwise 2^floor(log2 n) - 1.
- R5: `ra_valid` is high exactly while running with reads enabled, fewer than n reads have been accepted and fewer than 50 accepted reads are still without a read-data beat.
- R6: In read-only mode `rd_ready` stays high for the whole run.
- R7: In copy mode `rd_ready` is high only when `wa_ready` and `wd_ready` are both high, and every read-data beat issues a write pair in the same cycle with `wd_data` equal to `rd_data`.
- R8: In write-only mode a write pair issues whenever fewer than n writes have been sent and both write readies are high; `wd_data` is the write index (low bits).
- R9: `wa_valid` and `wd_valid` are always equal and are high only when both `wa_ready` and `wd_ready` are high.
- R10: `wr_ready` is high exactly while running with writes enabled; each acknowledge beat with `wr_count` = k credits k+1 writes.
- R11: `done` rises at the clock edge that accepts the final needed response (acknowledged writes reach n when writing, else read beats reach n), stays high while idle and clears at the next accepted start.
- R12: During reset all valids, readies and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only when idle |
| cfg_len | input | LEN_W | Element count n |
| cfg_read | input | 1 | Enable reads |
| cfg_write | input | 1 | Enable writes |
| cfg_random | input | 1 | Pseudo-random addressing |
| done | output | 1 | Run complete |
| ra_valid | output | 1 | Read address valid |
| ra_ready | input | 1 | Read address ready |
| ra_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_ready | output | 1 | Read data ready |
| rd_data | input | DATA_W | Read data |
| wa_valid | output | 1 | Write address valid |
| wa_ready | input | 1 | Write address ready |
| wa_addr | output | ADDR_W | Write address |
| wd_valid | output | 1 | Write data valid |
| wd_ready | input | 1 | Write data ready |
| wd_data | output | DATA_W | Write data |
| wr_valid | input | 1 | Write acknowledge valid |
| wr_ready | output | 1 | Write acknowledge ready |
| wr_count | input | ACK_W | Acknowledge covers wr_count+1 writes |

## Verification
The bench runs read latency well above 50 cycles so the in-flight cap is reached; a design that miscounts outstanding reads would keep `ra_valid` high past the cap or stall for good. Copy mode is driven with the two write readies toggling independently, which catches a design that consumes a read beat while only one write queue could take it and so loses or splits a write-back. Small and odd lengths (5, 17, 300) expose a wrong window mask as out-of-window addresses, multi-write acknowledges expose completion that counts beats instead of credits, and a start pulse mid-run exposes a design that re-latches its configuration.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;
  typedef enum logic {TG_IDLE = 1'b0, TG_RUN = 1'b1} tg_state_e;
  localparam int unsigned TG_LFSR_W = 16;
  localparam logic [TG_LFSR_W-1:0] TG_SEED = 16'hBEEF;
  // feedback taps at bits 15, 13, 12, 10
  localparam logic [TG_LFSR_W-1:0] TG_TAPS = 16'hB400;
endpackage

// File: rtl/tg_lfsr.sv
`timescale 1ns/1ps
module tg_lfsr #(
  parameter int unsigned W = tg_pkg::TG_LFSR_W,
  parameter logic [W-1:0] SEED = tg_pkg::TG_SEED,
  parameter logic [W-1:0] TAPS = tg_pkg::TG_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n || load) state <= SEED;
    else if (step)      state <= {state[W-2:0], fb};
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/tg_win_mask.sv
`timescale 1ns/1ps
module tg_win_mask #(
  parameter int unsigned LEN_W = 32,
  parameter int unsigned W     = tg_pkg::TG_LFSR_W
) (
  input  logic [LEN_W-1:0] len,
  output logic [W-1:0]     mask
);
  localparam logic [LEN_W:0] ONE = (LEN_W+1)'(1);

  always_comb begin
    int unsigned sh;
    sh = 0;
    for (int i = 1; i <= int'(W); i++) begin
      if ({1'b0, len} < (ONE << i)) sh = sh + 1;
    end
    mask = {W{1'b1}} >> sh;
  end
endmodule

// File: rtl/tg_addr_gen.sv
`timescale 1ns/1ps
module tg_addr_gen #(
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned W      = tg_pkg::TG_LFSR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              rand_mode,
  input  logic [W-1:0]      mask,
  output logic [LEN_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  logic [W-1:0] lfsr_q;

  tg_lfsr #(.W(W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (clear),
    .step  (advance && !clear),
    .state (lfsr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clear) idx <= '0;
    else if (advance)    idx <= idx + LEN_W'(1);
  end

  assign addr = rand_mode ? ADDR_W'(lfsr_q & mask) : ADDR_W'(idx);

  // R4
  rand_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rand_mode |-> ((addr & ~ADDR_W'(mask)) == '0));
  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> (idx == $past(idx) + LEN_W'(1)));
endmodule

// File: rtl/bw_traffic_gen.sv
`timescale 1ns/1ps
module bw_traffic_gen #(
  parameter int unsigned LEN_W     = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ACK_W     = 8,
  parameter int unsigned MAX_OUTST = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_read,
  input  logic              cfg_write,
  input  logic              cfg_random,
  output logic              done,
  output logic              ra_valid,
  input  logic              ra_ready,
  output logic [ADDR_W-1:0] ra_addr,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wa_valid,
  input  logic              wa_ready,
  output logic [ADDR_W-1:0] wa_addr,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [DATA_W-1:0] wd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ACK_W-1:0]  wr_count
);
  import tg_pkg::*;
  localparam int unsigned LW = TG_LFSR_W;
  localparam int unsigned NDIR = 2;   // 0: read, 1: write

  tg_state_e        state;
  logic [LEN_W-1:0] len_q;
  logic             rd_en, wr_en, rand_en;
  logic [LEN_W-1:0] rd_resp_cnt, rd_resp_nxt;
  logic [LEN_W:0]   wr_ack_cnt, wr_ack_nxt;
  logic [LW-1:0]    mask;
  logic             busy, start_ok, no_work, finish;
  logic             ra_fire, rd_fire, wr_go, ack_fire;
  logic [NDIR-1:0]  adv;
  logic [LEN_W-1:0] idx  [NDIR];
  logic [ADDR_W-1:0] addr [NDIR];

  assign busy     = (state == TG_RUN);
  assign start_ok = start && !busy;
  assign no_work  = (!cfg_read && !cfg_write) || (cfg_len == '0);

  tg_win_mask #(.LEN_W(LEN_W), .W(LW)) u_mask (.len(len_q), .mask(mask));

  generate
    for (genvar d = 0; d < int'(NDIR); d++) begin : g_dir
      tg_addr_gen #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .W(LW)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .advance   (adv[d]),
        .rand_mode (rand_en),
        .mask      (mask),
        .idx       (idx[d]),
        .addr      (addr[d])
      );
    end
  endgenerate

  // read request side: bounded by n and by reads in flight
  assign ra_valid = busy && rd_en && (idx[0] < len_q) &&
                    ({1'b0, idx[0]} < {1'b0, rd_resp_cnt} + (LEN_W+1)'(MAX_OUTST));
  assign ra_addr  = addr[0];
  assign ra_fire  = ra_valid && ra_ready;

  // read data side: in copy mode only when the write pair can move
  assign rd_ready = busy && rd_en && (!wr_en || (wa_ready && wd_ready));
  assign rd_fire  = rd_valid && rd_ready;

  // write pair
  assign wr_go    = busy && wr_en && wa_ready && wd_ready &&
                    (rd_en ? rd_valid : (idx[1] < len_q));
  assign wa_valid = wr_go;
  assign wd_valid = wr_go;
  assign wa_addr  = addr[1];
  assign wd_data  = rd_en ? rd_data : DATA_W'(idx[1]);

  assign adv = {wr_go, ra_fire};

  // acknowledge side
  assign wr_ready = busy && wr_en;
  assign ack_fire = wr_valid && wr_ready;

  assign rd_resp_nxt = rd_resp_cnt + LEN_W'(rd_fire);
  assign wr_ack_nxt  = wr_ack_cnt +
                       (ack_fire ? ((LEN_W+1)'(wr_count) + (LEN_W+1)'(1)) : '0);
  assign finish = busy && (wr_en ? (wr_ack_nxt >= {1'b0, len_q})
                                 : (rd_resp_nxt >= len_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= TG_IDLE;
      len_q       <= '0;
      rd_en       <= 1'b0;
      wr_en       <= 1'b0;
      rand_en     <= 1'b0;
      done        <= 1'b0;
      rd_resp_cnt <= '0;
      wr_ack_cnt  <= '0;
    end else if (start_ok) begin
      len_q       <= cfg_len;
      rd_en       <= cfg_read;
      wr_en       <= cfg_write;
      rand_en     <= cfg_random;
      rd_resp_cnt <= '0;
      wr_ack_cnt  <= '0;
      done        <= no_work;
      state       <= no_work ? TG_IDLE : TG_RUN;
    end else if (busy) begin
      rd_resp_cnt <= rd_resp_nxt;
      wr_ack_cnt  <= wr_ack_nxt;
      if (finish) begin
        state <= TG_IDLE;
        done  <= 1'b1;
      end
    end
  end

  // R5
  rd_outst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (({1'b0, idx[0]} - {1'b0, rd_resp_cnt}) <= (LEN_W+1)'(MAX_OUTST)));
  // R9
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_valid || wd_valid) |-> (wa_valid && wd_valid && wa_ready && wd_ready));
  // R7
  copy_couple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && rd_valid && rd_ready) |-> (wa_valid && wd_valid && wd_data == rd_data));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(ra_valid || rd_ready || wa_valid || wr_ready));
  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && done && !start) |=> done);
  // R10
  ack_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && wr_valid && wr_ready) |=>
      (wr_ack_cnt == $past(wr_ack_cnt) + (LEN_W+1)'($past(wr_count)) + (LEN_W+1)'(1)));
endmodule

// File: tb/bw_traffic_gen_test.sv
`timescale 1ns/1ps
module bw_traffic_gen_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, cfg_read = 1'b0, cfg_write = 1'b0, cfg_random = 1'b0;
  logic [31:0] cfg_len = '0;
  logic        done, ra_valid, ra_ready = 1'b0, rd_valid = 1'b0, rd_ready;
  logic        wa_valid, wa_ready = 1'b0, wd_valid, wd_ready = 1'b0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [31:0] ra_addr, rd_data = '0, wa_addr, wd_data;
  logic [7:0]  wr_count = '0;

  always #10 clk = ~clk;   // 50 MHz

  bw_traffic_gen uut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  // reference model state
  bit m_busy = 0, m_done = 0, m_rd = 0, m_wr = 0, m_rand = 0;
  longint m_len = 0, rd_iss = 0, rd_rsp = 0, wr_iss = 0, wr_ack = 0;
  bit [15:0] lr = 16'hBEEF, lw = 16'hBEEF;
  // memory environment
  int lat = 4, pct = 70, wpend = 0, n_ra = 0, n_wr = 0;
  int rq_time[$];
  logic [31:0] rq_addr[$];
  // scenario drive
  bit s_start = 0, s_r = 0, s_w = 0, s_x = 0;
  longint s_len = 0;

  function automatic bit [15:0] nx(bit [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic longint win(longint n);
    longint m = 16'hFFFF;
    for (int i = 16; i >= 1; i--) if (n < (longint'(1) << i)) m = m >> 1;
    return m;
  endfunction

  task automatic chk(string tag, longint act, longint exp, string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit e_rav, e_rdr, e_wv, e_wrr;
    longint msk, e_raa, e_waa, e_wd;
    @(negedge clk);
    cyc++;
    start = s_start; cfg_len = 32'(s_len);
    cfg_read = s_r; cfg_write = s_w; cfg_random = s_x;
    ra_ready = ($urandom % 100) < pct;
    wa_ready = ($urandom % 100) < pct;
    wd_ready = ($urandom % 100) < pct;
    if (rq_time.size() > 0 && cyc >= rq_time[0] && ($urandom % 4) != 0) begin
      rd_valid = 1'b1; rd_data = rq_addr[0] * 32'd3 + 32'h1000;
    end else begin
      rd_valid = 1'b0; rd_data = $urandom;
    end
    wr_valid = (wpend > 0) && ($urandom % 2 == 1);
    wr_count = wr_valid ? 8'($urandom % ((wpend < 4) ? wpend : 4)) : 8'($urandom % 8);
    #1;
    msk   = win(m_len);
    e_rav = m_busy && m_rd && rd_iss < m_len && rd_iss < rd_rsp + 50;
    e_raa = m_rand ? (longint'(lr) & msk) : rd_iss;
    e_rdr = m_busy && m_rd && (!m_wr || (wa_ready && wd_ready));
    e_wv  = m_busy && m_wr && wa_ready && wd_ready && (m_rd ? rd_valid : wr_iss < m_len);
    e_waa = m_rand ? (longint'(lw) & msk) : wr_iss;
    e_wd  = m_rd ? longint'(rd_data) : (wr_iss & 64'hFFFF_FFFF);
    e_wrr = m_busy && m_wr;
    chk("R5", ra_valid, e_rav, "ra_valid");
    if (e_rav) chk(m_rand ? "R4" : "R3", ra_addr, e_raa, "ra_addr");
    chk(m_wr ? "R7" : "R6", rd_ready, e_rdr, "rd_ready");
    chk("R9", wa_valid, e_wv, "wa_valid");
    chk("R9", wd_valid, e_wv, "wd_valid");
    if (e_wv) begin
      chk(m_rand ? "R4" : "R3", wa_addr, e_waa, "wa_addr");
      chk(m_rd ? "R7" : "R8", wd_data, e_wd, "wd_data");
    end
    chk("R10", wr_ready, e_wrr, "wr_ready");
    chk("R11", done, m_done, "done");
    // environment bookkeeping from the ports
    if (ra_valid && ra_ready) begin
      rq_addr.push_back(ra_addr); rq_time.push_back(cyc + lat); n_ra++;
    end
    if (rd_valid && rd_ready) begin
      void'(rq_addr.pop_front()); void'(rq_time.pop_front());
    end
    if (wa_valid && wa_ready && wd_valid && wd_ready) begin wpend++; n_wr++; end
    if (wr_valid && wr_ready) wpend -= int'(wr_count) + 1;
    // reference model advance
    if (!m_busy) begin
      if (start) begin
        m_len = s_len; m_rd = s_r; m_wr = s_w; m_rand = s_x;
        rd_iss = 0; rd_rsp = 0; wr_iss = 0; wr_ack = 0;
        lr = 16'hBEEF; lw = 16'hBEEF;
        if ((!s_r && !s_w) || s_len == 0) m_done = 1;
        else begin m_busy = 1; m_done = 0; end
      end
    end else begin
      if (e_rav && ra_ready) begin rd_iss++; lr = nx(lr); end
      if (rd_valid && e_rdr) rd_rsp++;
      if (e_wv) begin wr_iss++; lw = nx(lw); end
      if (wr_valid && e_wrr) wr_ack += longint'(wr_count) + 1;
      if (m_wr ? (wr_ack >= m_len) : (rd_rsp >= m_len)) begin
        m_busy = 0; m_done = 1;
      end
    end
  endtask

  task automatic run(longint len, bit r, bit w, bit x, int l, int p, bit mid_start);
    int i;
    lat = l; pct = p; n_ra = 0; n_wr = 0;
    s_len = len; s_r = r; s_w = w; s_x = x; s_start = 1;
    step();
    s_start = 0;
    i = 0;
    while (m_busy && i < 30000) begin
      if (mid_start && i == 5) begin
        s_start = 1; s_len = 3; s_r = 0; s_w = 1;   // must be ignored
      end
      step();
      s_start = 0;
      i++;
    end
    if (m_busy) begin
      nchk++; nfail++;
      $display("FAIL R11 watchdog actual=busy expected=done (len %0d)", len);
    end
    repeat (3) step();
    if ((!r && !w) || len == 0) begin
      chk("R2", done, 1, "done after empty start");
      chk("R2", n_ra + n_wr, 0, "request count");
    end else begin
      if (r) chk("R1", n_ra, len, "reads accepted");
      if (w) chk("R1", n_wr, len, "writes accepted");
    end
    rq_addr.delete(); rq_time.delete(); wpend = 0;
  endtask

  initial begin
    // R12: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R12", {ra_valid, rd_ready, wa_valid, wd_valid, wr_ready}, 0, "handshakes in reset");
      chk("R12", done, 0, "done in reset");
    end
    rst_n = 1'b1;
    run(20,  1, 0, 0, 5,  70, 1);   // read, sequential, ignored restart
    run(17,  0, 1, 0, 3,  60, 0);   // write only
    run(30,  1, 1, 0, 6,  50, 0);   // copy
    run(100, 1, 0, 1, 90, 90, 0);   // random read, cap reached
    run(300, 1, 1, 1, 10, 60, 0);   // random copy
    run(5,   0, 1, 1, 4,  80, 0);   // random write, 4-wide window
    run(40,  1, 1, 0, 70, 95, 0);   // copy with cap
    run(9,   0, 0, 0, 4,  70, 0);   // no direction
    run(0,   1, 1, 0, 4,  70, 0);   // zero length
    run(12,  1, 0, 0, 2, 100, 0);   // read, full-rate
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule